// File: doc/BRIEF.md
# Bounded Page Replacement Selector

This block picks the victim frame of a 16-frame task memory for an incoming page. A configuration load sets a lower and an upper frame bound and a policy code. Automatic policies may only pick frames from the lower bound through the upper bound, inclusive. Each request produces one chosen frame. With the frame comes a flag that says whether the frame holds modified data, so the page mover writes the old contents back to main memory before it overwrites them.

There are seven policies:
- an in-order sweep, on single frames or on aligned even/odd pairs;
- a descending sweep;
- a pseudo-random pick, on single frames or on aligned pairs;
- a most-recently-used pick driven by hit notifications;
- a directed mode that passes through the frame number supplied with the request.

The hit notifications also carry a write flag, which feeds the modified-data tracking.

Top module: `frame_victim_sel`

## Requirements
- R1: After reset the bounds are 0 and 14, the policy code is 4 (in-order sweep), `cfg_err` is low and `sel_valid` is low.
- R2: `cfg_err` is high when the lower bound exceeds the upper bound, when the bounds are 0 and 15, when the policy code is 7, or when a pair policy (code 2 or 5) has no whole aligned pair inside the bounds. A request made while `cfg_err` is high produces no `sel_valid`.
- R3: A request with `cfg_err` low raises `sel_valid` for exactly the following cycle. In every policy except code 6, `sel_frame` then lies within the bounds.
- R4: Code 4 (in-order sweep) returns lower, lower+1, … up to upper, then wraps to lower. Each configuration load restarts it at the lower bound.
- R5: Code 3 (descending sweep) returns upper, upper-1, … down to lower, then wraps to upper. Each configuration load restarts it at the upper bound.
- R6: Code 5 (in-order pair sweep) returns the even frame of each aligned pair that lies wholly inside the bounds, in ascending order, and wraps to the first such pair. The reported frame is always even.
- R7: Code 1 (random) returns a frame within the bounds. Code 2 (random pairs) returns the even frame of a whole aligned pair inside the bounds.
- R8: Code 0 (most recently used) returns the frame of the latest hit notification that fell inside the bounds. Before any such hit since the last configuration load, it returns the lower bound. Hits outside the bounds leave its choice unchanged.
- R9: Code 6 (directed) returns `prog_frame` unchanged, even when it lies outside the bounds.
- R10: A hit notification with `use_write` high marks its frame modified. `sel_dirty` reports that mark for the chosen frame, and choosing a frame clears its mark. A notification with `use_write` low marks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load bounds and policy code |
| cfg_lo | input | 4 | Lower frame bound |
| cfg_hi | input | 4 | Upper frame bound |
| cfg_mode | input | 3 | Policy code (0 MRU, 1 random, 2 random pairs, 3 descending, 4 in-order, 5 in-order pairs, 6 directed, 7 invalid) |
| req | input | 1 | Request a victim frame |
| prog_frame | input | 4 | Frame used by the directed policy |
| use_valid | input | 1 | Hit notification strobe |
| use_write | input | 1 | Hit notification was a write |
| use_frame | input | 4 | Frame of the hit notification |
| sel_valid | output | 1 | Chosen frame is valid this cycle |
| sel_frame | output | 4 | Chosen frame |
| sel_dirty | output | 1 | Chosen frame holds modified data |
| cfg_err | output | 1 | Current configuration is unusable |

## Verification
Each policy stores its state in a sweep pointer, a recency register or a modified-mark bit. A corrupted sweep pointer shows on the very next request as a frame out of sequence. A stale recency register shows as the lower bound, or as an old frame, where the latest in-window hit was expected. A wrong modified mark shows as a flipped `sel_dirty` the first time the frame is chosen. A wrong error decode shows as a missing or unexpected `sel_valid` one cycle after a request. Sweeping every pair of bounds under each automatic policy makes each of these visible within one wrap of the window.

// File: rtl/fvs_pkg.sv
package fvs_pkg;
  localparam int FRAME_W = 4;
  localparam int NFRAMES = 1 << FRAME_W;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [FRAME_W:0]   wide_t;

  typedef enum logic [2:0] {
    MODE_MRU   = 3'd0,
    MODE_RAND  = 3'd1,
    MODE_RANDP = 3'd2,
    MODE_REV   = 3'd3,
    MODE_FIFO  = 3'd4,
    MODE_FIFOP = 3'd5,
    MODE_PROG  = 3'd6,
    MODE_RSVD  = 3'd7
  } mode_e;

  // lowest even frame not below lo
  function automatic wide_t pair_first(frame_t lo);
    return {1'b0, lo} + wide_t'(lo[0]);
  endfunction

  // even frame of the highest pair whose odd partner is not above hi
  function automatic wide_t pair_last(frame_t hi);
    wide_t t;
    t = ({1'b0, hi} + wide_t'(1)) & ~wide_t'(1);
    return t - wide_t'(2);
  endfunction

  function automatic logic pair_exists(frame_t lo, frame_t hi);
    return (pair_first(lo) + wide_t'(1)) <= {1'b0, hi};
  endfunction

  function automatic logic is_pair_mode(mode_e m);
    return (m == MODE_FIFOP) || (m == MODE_RANDP);
  endfunction
endpackage

// File: rtl/fvs_cfg.sv
module fvs_cfg
  import fvs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t lo_in,
  input  frame_t hi_in,
  input  mode_e  mode_in,
  output frame_t lo,
  output frame_t hi,
  output mode_e  mode,
  output logic   err
);
  logic range_bad, full_win, pair_bad, mode_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo   <= '0;
      hi   <= frame_t'(NFRAMES - 2);
      mode <= MODE_FIFO;
    end else if (load) begin
      lo   <= lo_in;
      hi   <= hi_in;
      mode <= mode_in;
    end
  end

  always_comb begin
    range_bad = lo > hi;
    full_win  = (lo == '0) && (hi == '1);
    pair_bad  = is_pair_mode(mode) && !pair_exists(lo, hi);
    mode_bad  = mode == MODE_RSVD;
    err       = range_bad || full_win || pair_bad || mode_bad;
  end
endmodule

// File: rtl/fvs_ptr.sv
module fvs_ptr
  import fvs_pkg::*;
#(
  parameter bit     DESCEND = 1'b0,
  parameter int     STEP    = 1,
  parameter frame_t RST_PTR = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t ld_lo,
  input  frame_t ld_hi,
  input  frame_t lo,
  input  frame_t hi,
  input  logic   adv,
  output frame_t ptr
);
  localparam frame_t STEP_F = frame_t'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= RST_PTR;
    else if (load)
      ptr <= DESCEND ? ld_hi : ld_lo;
    else if (adv) begin
      if (DESCEND)
        ptr <= (ptr <= lo) ? hi : ptr - STEP_F;
      else
        ptr <= (ptr >= hi) ? lo : ptr + STEP_F;
    end
  end
endmodule

// File: rtl/fvs_lfsr.sv
module fvs_lfsr #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= {{(W-1){1'b0}}, 1'b1};
    else
      state <= {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
  end
endmodule

// File: rtl/fvs_usage.sv
module fvs_usage
  import fvs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_mru,
  input  frame_t lo,
  input  frame_t hi,
  input  logic   use_valid,
  input  logic   use_write,
  input  frame_t use_frame,
  input  logic   fire,
  input  frame_t chosen,
  output frame_t mru_frame,
  output logic   mru_valid,
  output logic   chosen_dirty
);
  logic [NFRAMES-1:0] dirty;
  logic               hit_in_win;

  assign hit_in_win = use_valid && (use_frame >= lo) && (use_frame <= hi);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_mru) begin
      mru_valid <= 1'b0;
      mru_frame <= '0;
    end else if (hit_in_win) begin
      mru_valid <= 1'b1;
      mru_frame <= use_frame;
    end
  end

  for (genvar i = 0; i < NFRAMES; i++) begin : g_dirty
    always_ff @(posedge clk) begin
      if (!rst_n)
        dirty[i] <= 1'b0;
      else if (fire && (chosen == frame_t'(i)))
        dirty[i] <= 1'b0;
      else if (use_valid && use_write && (use_frame == frame_t'(i)))
        dirty[i] <= 1'b1;
    end
  end

  assign chosen_dirty = dirty[chosen];
endmodule

// File: rtl/frame_victim_sel.sv
module frame_victim_sel
  import fvs_pkg::*;
#(
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [FRAME_W-1:0] cfg_lo,
  input  logic [FRAME_W-1:0] cfg_hi,
  input  logic [2:0]         cfg_mode,
  input  logic               req,
  input  logic [FRAME_W-1:0] prog_frame,
  input  logic               use_valid,
  input  logic               use_write,
  input  logic [FRAME_W-1:0] use_frame,
  output logic               sel_valid,
  output logic [FRAME_W-1:0] sel_frame,
  output logic               sel_dirty,
  output logic               cfg_err
);
  // fold a random word into n slots (n >= 1)
  function automatic frame_t fold(logic [LFSR_W-1:0] r, wide_t n);
    if (n == '0) return '0;
    return frame_t'(r % LFSR_W'(n));
  endfunction

  frame_t cur_lo, cur_hi;
  mode_e  cur_mode;
  frame_t fifo_ptr, rev_ptr, pair_ptr;
  frame_t p_lo, p_hi, ld_plo, ld_phi;
  frame_t mru_frame, chosen, rnd_frame, rnd_pair;
  logic   mru_valid, chosen_dirty, fire;
  logic [LFSR_W-1:0] lfsr;
  wide_t  win_size, pair_cnt;

  fvs_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .lo_in(cfg_lo), .hi_in(cfg_hi), .mode_in(mode_e'(cfg_mode)),
    .lo(cur_lo), .hi(cur_hi), .mode(cur_mode), .err(cfg_err)
  );

  assign p_lo   = frame_t'(pair_first(cur_lo));
  assign p_hi   = frame_t'(pair_last(cur_hi));
  assign ld_plo = frame_t'(pair_first(cfg_lo));
  assign ld_phi = frame_t'(pair_last(cfg_hi));
  assign fire   = req && !cfg_err;

  fvs_ptr #(.DESCEND(1'b0), .STEP(1), .RST_PTR(frame_t'(0))) u_fifo (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .ld_lo(cfg_lo), .ld_hi(cfg_hi),
    .lo(cur_lo), .hi(cur_hi), .adv(fire && cur_mode == MODE_FIFO), .ptr(fifo_ptr)
  );

  fvs_ptr #(.DESCEND(1'b1), .STEP(1), .RST_PTR(frame_t'(NFRAMES - 2))) u_rev (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .ld_lo(cfg_lo), .ld_hi(cfg_hi),
    .lo(cur_lo), .hi(cur_hi), .adv(fire && cur_mode == MODE_REV), .ptr(rev_ptr)
  );

  fvs_ptr #(.DESCEND(1'b0), .STEP(2), .RST_PTR(frame_t'(0))) u_pair (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .ld_lo(ld_plo), .ld_hi(ld_phi),
    .lo(p_lo), .hi(p_hi), .adv(fire && cur_mode == MODE_FIFOP), .ptr(pair_ptr)
  );

  fvs_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(lfsr)
  );

  fvs_usage u_use (
    .clk(clk), .rst_n(rst_n), .clr_mru(cfg_load), .lo(cur_lo), .hi(cur_hi),
    .use_valid(use_valid), .use_write(use_write), .use_frame(use_frame),
    .fire(fire), .chosen(chosen),
    .mru_frame(mru_frame), .mru_valid(mru_valid), .chosen_dirty(chosen_dirty)
  );

  always_comb begin
    win_size  = {1'b0, cur_hi} - {1'b0, cur_lo} + wide_t'(1);
    pair_cnt  = ((wide_t'(p_hi) - wide_t'(p_lo)) >> 1) + wide_t'(1);
    rnd_frame = cur_lo + fold(lfsr, win_size);
    rnd_pair  = p_lo + frame_t'(fold(lfsr, pair_cnt) << 1);
    unique case (cur_mode)
      MODE_MRU:   chosen = mru_valid ? mru_frame : cur_lo;
      MODE_RAND:  chosen = rnd_frame;
      MODE_RANDP: chosen = rnd_pair;
      MODE_REV:   chosen = rev_ptr;
      MODE_FIFO:  chosen = fifo_ptr;
      MODE_FIFOP: chosen = pair_ptr;
      MODE_PROG:  chosen = prog_frame;
      default:    chosen = cur_lo;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_frame <= '0;
      sel_dirty <= 1'b0;
    end else begin
      sel_valid <= fire;
      if (fire) begin
        sel_frame <= chosen;
        sel_dirty <= chosen_dirty;
      end
    end
  end
endmodule

// File: rtl/fvs_checker.sv
module fvs_checker
  import fvs_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   req,
  input logic   cfg_err,
  input logic   fire,
  input frame_t prog_frame,
  input logic   sel_valid,
  input frame_t sel_frame,
  input frame_t cur_lo,
  input frame_t cur_hi,
  input mode_e  cur_mode
);
  AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req && cfg_err |=> !sel_valid); // R2

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> $past(req) && !$past(cfg_err)); // R3

  AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && $past(cur_mode) != MODE_PROG
      |-> sel_frame >= $past(cur_lo) && sel_frame <= $past(cur_hi)); // R3

  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && is_pair_mode($past(cur_mode)) |-> !sel_frame[0]); // R6

  AST_PROG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cur_mode == MODE_PROG |=> sel_frame == $past(prog_frame)); // R9
endmodule

bind frame_victim_sel fvs_checker i_fvs_checker (
  .clk(clk), .rst_n(rst_n), .req(req), .cfg_err(cfg_err), .fire(fire),
  .prog_frame(prog_frame), .sel_valid(sel_valid), .sel_frame(sel_frame),
  .cur_lo(cur_lo), .cur_hi(cur_hi), .cur_mode(cur_mode)
);

// File: tb/test_frame_victim_sel.sv
module test_frame_victim_sel;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic [3:0] cfg_lo = '0, cfg_hi = '0;
  logic [2:0] cfg_mode = '0;
  logic       req = 1'b0;
  logic [3:0] prog_frame = '0;
  logic       use_valid = 1'b0, use_write = 1'b0;
  logic [3:0] use_frame = '0;
  logic       sel_valid, sel_dirty, cfg_err;
  logic [3:0] sel_frame;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  frame_victim_sel i_frame_victim_sel (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_mode(cfg_mode), .req(req), .prog_frame(prog_frame), .use_valid(use_valid),
    .use_write(use_write), .use_frame(use_frame), .sel_valid(sel_valid),
    .sel_frame(sel_frame), .sel_dirty(sel_dirty), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(int lo, int hi, int mode);
    @(negedge clk);
    cfg_load = 1'b1; cfg_lo = 4'(lo); cfg_hi = 4'(hi); cfg_mode = 3'(mode);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic request(output bit v, output int f, output bit d);
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    v = sel_valid; f = int'(sel_frame); d = sel_dirty;
  endtask

  task automatic notify(int fr, bit wr);
    @(negedge clk);
    use_valid = 1'b1; use_frame = 4'(fr); use_write = wr;
    @(negedge clk);
    use_valid = 1'b0; use_write = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    bit v, d;
    int f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(sel_valid == 1'b0, "R1 sel_valid", int'(sel_valid), 0);
    check(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
    request(v, f, d);
    check(v && f == 0, "R1 default sweep start", f, 0);
    request(v, f, d);
    check(v && f == 1, "R1 default sweep next", f, 1);

    // sweep all bounds under the automatic policies
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = 0; hi < 16; hi++) begin
        bit base_bad;
        int pe, pl;
        base_bad = (lo > hi) || (lo == 0 && hi == 15);
        pe = lo + (lo % 2);
        pl = (hi % 2 == 1) ? hi - 1 : hi - 2;

        // R4: ascending sweep
        load(lo, hi, 4);
        check(cfg_err == base_bad, "R2 err fifo", int'(cfg_err), int'(base_bad));
        if (base_bad) begin
          request(v, f, d);
          check(!v, "R2 no select", int'(v), 0);
        end else begin
          for (int k = 0; k <= hi - lo + 1; k++) begin
            int e;
            e = (k == hi - lo + 1) ? lo : lo + k;
            request(v, f, d);
            check(v && f == e, "R4 fifo order", f, e);
          end
          // R5: descending sweep
          load(lo, hi, 3);
          for (int k = 0; k <= hi - lo + 1; k++) begin
            int e;
            e = (k == hi - lo + 1) ? hi : hi - k;
            request(v, f, d);
            check(v && f == e, "R5 reverse order", f, e);
          end
          // R7: random inside window
          load(lo, hi, 1);
          for (int k = 0; k < 6; k++) begin
            request(v, f, d);
            check(v && f >= lo && f <= hi, "R7 random in window", f, lo);
          end
        end

        // R6: pair sweep
        load(lo, hi, 5);
        begin
          bit pbad;
          pbad = base_bad || (pe > pl);
          check(cfg_err == pbad, "R2 err pairs", int'(cfg_err), int'(pbad));
          if (!pbad) begin
            int np;
            np = (pl - pe) / 2 + 1;
            for (int k = 0; k <= np; k++) begin
              int e;
              e = (k == np) ? pe : pe + 2 * k;
              request(v, f, d);
              check(v && f == e, "R6 pair order", f, e);
            end
            load(lo, hi, 2);
            for (int k = 0; k < 4; k++) begin
              request(v, f, d);
              check(v && f % 2 == 0 && f >= pe && f <= pl, "R7 random pair", f, pe);
            end
          end
        end
      end
    end

    // R2: reserved code
    load(1, 4, 7);
    check(cfg_err == 1'b1, "R2 reserved code", int'(cfg_err), 1);
    request(v, f, d);
    check(!v, "R2 reserved no select", int'(v), 0);

    // R8: most recently used
    load(4, 9, 0);
    request(v, f, d);
    check(v && f == 4, "R8 no hit yet", f, 4);
    notify(7, 1'b0);
    request(v, f, d);
    check(v && f == 7, "R8 latest hit", f, 7);
    notify(12, 1'b0);
    request(v, f, d);
    check(v && f == 7, "R8 outside hit ignored", f, 7);
    notify(5, 1'b0);
    request(v, f, d);
    check(v && f == 5, "R8 newer hit", f, 5);
    load(4, 9, 0);
    request(v, f, d);
    check(v && f == 4, "R8 cleared by load", f, 4);

    // R9: directed
    load(2, 5, 6);
    prog_frame = 4'd15;
    request(v, f, d);
    check(v && f == 15, "R9 directed outside", f, 15);
    prog_frame = 4'd3;
    request(v, f, d);
    check(v && f == 3, "R9 directed inside", f, 3);

    // R10: modified marks
    load(8, 10, 4);
    notify(9, 1'b1);
    notify(10, 1'b0);
    request(v, f, d);
    check(f == 8 && d == 1'b0, "R10 clean frame", int'(d), 0);
    request(v, f, d);
    check(f == 9 && d == 1'b1, "R10 written frame", int'(d), 1);
    request(v, f, d);
    check(f == 10 && d == 1'b0, "R10 read hit not marked", int'(d), 0);
    request(v, f, d);
    check(f == 8 && d == 1'b0, "R10 wrap clean", int'(d), 0);
    request(v, f, d);
    check(f == 9 && d == 1'b0, "R10 mark cleared", int'(d), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule